// File: doc/BRIEF.md
# Variable-Resolution Duty-Cycle DAC Bank

This block produces four pulse-width logic outputs, one for each electrode drive of a two-axis positioner (north, south, east, west). An external low-pass filter turns each output into an analog level proportional to its duty cycle. A programmable divider derives a DAC clock enable from a fast free-running clock. A single 16-bit phase accumulator advances by a programmable step on each DAC clock tick and wraps modulo 65536. A small step gives fine resolution and a slow repetition rate. A large step gives coarse resolution and a fast repetition rate, so the two are traded with one register.

Each channel compares its 16-bit setpoint with the shared phase. A processor or command decoder loads setpoints, the step and the divisor through an address/data/strobe write port, at any time and without a reset. New setpoints wait in a shadow register and take effect at the next period boundary. The DAC clock enable is brought out on its own pin so that it can be measured.

Top module: `duty_dac_bank`

## Requirements
- R1: After reset all four outputs are low, the step is 1 and the divisor is DIV_INIT (default 8), so `dck_tick` is high for one fast clock cycle in every DIV_INIT.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr`. Address 0 holds the north setpoint (`pwm_out[0]`), 1 south (`pwm_out[1]`), 2 east (`pwm_out[2]`), 3 west (`pwm_out[3]`), 4 the step and 5 the divisor (low DIV_W bits). Writes to addresses 6 and 7 change nothing.
- R3: With divisor D of 2 or more, `dck_tick` is high for exactly one fast clock cycle in every D. With divisor 0 or 1 it is high on every cycle.
- R4: On each tick the phase advances by the step modulo 65536, and it holds between ticks. A step of 0 acts as a step of 1.
- R5: Each output is high while the phase is strictly below that channel's applied setpoint. For a power-of-two step S, one period lasts 65536/S ticks, and ceil(setpoint/S) of those ticks are high.
- R6: A setpoint of 0 keeps its output constantly low. A setpoint of 65535 with a step of at least 2 keeps it constantly high.
- R7: A setpoint write takes effect only when the phase wraps past 65535. Until then the output follows the previous setpoint.
- R8: The step and the divisor can be rewritten at run time without a reset, and the new rate and period follow within one period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 4 | Duty-cycle outputs: bit 0 north, 1 south, 2 east, 3 west |
| dck_tick | output | 1 | DAC clock enable, for observation |

## Verification
The bench counts high cycles over windows that are whole multiples of the period. A wrong compare (less-or-equal instead of less-than), a lost step or an accumulator that freezes on a step of 0 therefore gives a count that differs from the one expected. It writes a new setpoint just after an output falls in mid-period and checks that the output stays low until the wrap. A design that applies setpoints at once would go high straight away. It also rewrites the divisor to larger values, to smaller values and to 0, counting `dck_tick` each time, and writes to the unused addresses to show that nothing moves. A divider that misses a shrinking divisor would stall or drift.

// File: rtl/duty_dac_bank.sv
module duty_dac_bank #(
  parameter int PH_W     = 16,
  parameter int DIV_W    = 8,
  parameter int NCH      = 4,
  parameter int DIV_INIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [PH_W-1:0]  wr_data,
  output logic [NCH-1:0]   pwm_out,
  output logic             dck_tick
);

  localparam logic [2:0] ADDR_STEP = 3'(NCH);
  localparam logic [2:0] ADDR_DIV  = 3'(NCH + 1);

  logic [DIV_W-1:0] div_q, cnt_q;
  logic [PH_W-1:0]  step_q, phase_q, phase_nx, step_eff;
  logic             carry, tick, wrap;
  logic [PH_W-1:0]  shadow_q [NCH];
  logic [PH_W-1:0]  active_q [NCH];

  assign tick     = (div_q <= DIV_W'(1)) || (cnt_q >= div_q - DIV_W'(1));
  assign step_eff = (step_q == '0) ? PH_W'(1) : step_q;
  assign {carry, phase_nx} = {1'b0, phase_q} + {1'b0, step_eff};
  assign wrap     = tick && carry;
  assign dck_tick = tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(DIV_INIT);
      step_q <= PH_W'(1);
    end else if (wr_en) begin
      if (wr_addr == ADDR_DIV)  div_q  <= wr_data[DIV_W-1:0];
      if (wr_addr == ADDR_STEP) step_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= phase_nx;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end else begin
        if (wr_en && wr_addr == 3'(i)) shadow_q[i] <= wr_data;
        if (wrap) active_q[i] <= shadow_q[i];
      end
    end

    assign pwm_out[i] = phase_q < active_q[i];

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(active_q[i])); // R7
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q >= DIV_W'(2) && $stable(div_q)) |-> cnt_q < div_q); // R3

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q >= DIV_W'(2) && !(wr_en && wr_addr == ADDR_DIV)) |=> !tick); // R3

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q)); // R4

  AST_WRAP_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> phase_q < $past(step_eff)); // R4

endmodule

// File: tb/tb_duty_dac_bank.sv
module tb_duty_dac_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pwm_out;
  logic        dck_tick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  duty_dac_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                     .wr_data(wr_data), .pwm_out(pwm_out), .dck_tick(dck_tick));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_pwm(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) cnt++;
    end
  endtask

  task automatic count_tick(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dck_tick) cnt++;
    end
  endtask

  task automatic t_reset;
    int c;
    idle(3);
    check("R1 outputs low", int'(pwm_out), 0);
    count_tick(80, c);
    check("R1 default divisor ticks", c, 10);
    count_pwm(0, 64, c);
    check("R1 north low", c, 0);
  endtask

  task automatic t_basic;
    int c;
    wr(3'd5, 16'd1);
    wr(3'd4, 16'h1000);
    wr(3'd0, 16'h3000);
    wr(3'd1, 16'h8000);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'hFFFF);
    idle(40);
    count_pwm(0, 64, c); check("R5 north 0x3000", c, 12);
    count_pwm(1, 64, c); check("R5 south 0x8000", c, 32);
    count_pwm(2, 64, c); check("R6 east zero low", c, 0);
    count_pwm(3, 64, c); check("R6 west full high", c, 64);
    count_tick(20, c);   check("R3 divisor 1 every cycle", c, 20);
  endtask

  task automatic t_shadow;
    int c;
    int guard;
    guard = 0;
    while (!pwm_out[1] && guard < 100) begin @(negedge clk); guard++; end
    while (pwm_out[1] && guard < 100) begin @(negedge clk); guard++; end
    wr_en = 1; wr_addr = 3'd1; wr_data = 16'hFFFF;
    @(negedge clk);
    wr_en = 0;
    c = 0;
    for (int i = 0; i < 5; i++) begin
      if (pwm_out[1]) c++;
      @(negedge clk);
    end
    check("R7 no mid-period update", c, 0);
    idle(12);
    count_pwm(1, 32, c);
    check("R7 applied after wrap", c, 32);
  endtask

  task automatic t_step_change;
    int c;
    wr(3'd4, 16'h2000);
    idle(20);
    count_pwm(0, 64, c); check("R8 step 0x2000 north", c, 16);
    count_pwm(1, 64, c); check("R8 step 0x2000 south", c, 64);
  endtask

  task automatic t_ignored;
    int c;
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    idle(20);
    count_pwm(0, 64, c);  check("R2 addr 6/7 ignored pwm", c, 16);
    count_pwm(2, 64, c);  check("R2 addr 6/7 ignored east", c, 0);
    count_tick(20, c);    check("R2 addr 6/7 ignored divisor", c, 20);
  endtask

  task automatic t_divider;
    int c;
    wr(3'd5, 16'd3);
    idle(100);
    count_tick(99, c);   check("R3 divisor 3", c, 33);
    count_pwm(0, 96, c); check("R5 north at divisor 3", c, 24);
    wr(3'd5, 16'd5);
    idle(50);
    count_tick(100, c);  check("R8 divisor 5", c, 20);
    wr(3'd5, 16'd2);
    idle(10);
    count_tick(100, c);  check("R8 divisor shrink to 2", c, 50);
    wr(3'd5, 16'd0);
    idle(10);
    count_tick(50, c);   check("R3 divisor 0 every cycle", c, 50);
  endtask

  task automatic t_step0;
    int c;
    wr(3'd1, 16'h8000);
    idle(20);
    wr(3'd4, 16'h0000);
    idle(4);
    count_pwm(1, 65536, c);
    check("R4 step 0 acts as 1", c, 32768);
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    t_reset();
    t_basic();
    t_shadow();
    t_step_change();
    t_ignored();
    t_divider();
    t_step0();
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 190000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected done", n);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule